// File: doc/BRIEF.md
# CAN Transceiver Mode Controller

This block decides how a low-speed CAN transceiver inside a system basis chip is driven. Software writes a CAN mode request, a listen-only bit, a transmitter control bit, a partial networking select and an off-line timer select. The chip's system controller reports its own mode, and the analog side reports a transceiver supply failure and a filtered wake-up strobe. From these the block produces enables for the transmitter, receiver, supply and strong termination, the RXD low override, a fail flag and an interrupt pulse.

The transceiver is in one of five states. Active allows transmit and receive. On-line and Selective Sleep are the two Auto states, in which the bus stays supported but nothing is transmitted. Off-line is the idle state, and a supply-fault state keeps everything off until software retries. In the Auto states an off-line timer returns the transceiver to Off-line when no wake-up activity is seen for a programmed number of cycles.

Top module: `can_xcvr_mode_ctrl`

## Requirements
- R1: `can_mode_o` goes to 1 one cycle after a rising edge of `can_mode_i` if `sysc_mode_i` is Normal (2'b01) or Flash (2'b10). A rising edge while `sysc_mode_i` is Standby (2'b00) or Sleep (2'b11) is ignored. The bit clears one cycle after `can_mode_i` goes low or `sysc_mode_i` leaves Normal/Flash, and it stays clear until the next rising edge.
- R2: One cycle after `can_mode_o` is 1 in Off-line, On-line or Selective Sleep, the block is Active, with `tx_en_o`, `rx_en_o`, `term_strong_o` and `sup_en_o` all 1.
- R3: In Active, `tx_off_i`=1 forces `tx_en_o` to 0 in the same cycle, and `rx_en_o` stays 1.
- R4: `sup_fail_i`=1 in Active gives, one cycle later, all four enables at 0 and `fail_o`=1. It also gives `irq_o`=1 for exactly one cycle when `irq_en_i`=1.
- R5: In the fault state, a falling edge of `txc_i` (1 in one cycle, 0 in the next) returns the block to Active one cycle later, with the enables at 1 and `fail_o` at 0. A further supply failure repeats R4, including a new interrupt. If `can_mode_o` is clear while in the fault state, the next state is Off-line.
- R6: When `can_mode_o` clears in Active, `tx_en_o` drops in the same cycle. One cycle later the block is in On-line if `pnc_i`=0, or in Selective Sleep if `pnc_i`=1. Both of these states have `tx_en_o`=0 and the other three enables at 1.
- R7: In Off-line, `wake_i` with `pnc_i`=0 moves the block to On-line one cycle later, with `rxd_low_o`=1. With `pnc_i`=1 the wake-up is ignored and all outputs stay 0.
- R8: In On-line, `wake_i` sets `rxd_low_o` one cycle later. It stays 1 until the state leaves On-line (mode bit or `pnc_i` set) and clears on that same edge. In Selective Sleep `rxd_low_o` stays 0 even when `wake_i` pulses.
- R9: In On-line or Selective Sleep, the block enters Off-line P cycles after the later of state entry and the last `wake_i`. P is LONG_CYC if `otsel_i`=1, or if no `wake_i` has been seen in an Auto state since Off-line was last entered. Otherwise P is SHORT_CYC.
- R10: During and after reset, the block is in Off-line with every output at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| can_mode_i | input | 1 | Software CAN mode request |
| tx_off_i | input | 1 | Listen-only request |
| txc_i | input | 1 | Transmitter control bit; a falling edge retries after a fault |
| pnc_i | input | 1 | Partial networking select: 1 = Selective Sleep |
| otsel_i | input | 1 | Off-line timer select: 1 = long period |
| sysc_mode_i | input | 2 | System controller mode: 00 Standby, 01 Normal, 10 Flash, 11 Sleep |
| irq_en_i | input | 1 | Interrupt enable for supply faults |
| sup_fail_i | input | 1 | Transceiver supply failure indication |
| wake_i | input | 1 | Filtered bus wake-up strobe |
| tx_en_o | output | 1 | Transmitter enable |
| rx_en_o | output | 1 | Receiver enable |
| term_strong_o | output | 1 | 1 = strong termination, 0 = floating |
| sup_en_o | output | 1 | Transceiver supply enable |
| rxd_low_o | output | 1 | Forces RXD low (wake-up pending) |
| fail_o | output | 1 | Supply fault state flag |
| irq_o | output | 1 | One-cycle interrupt request |
| can_mode_o | output | 1 | Effective CAN mode bit |

## Verification
The listen-only gating and the transmitter drop on mode clear are combinational, so they are due in the same cycle as the stimulus. The mode bit, each state change and the interrupt are due one cycle after their cause. Entry to Active is due two cycles after a rising `can_mode_i`, and an off-line timeout is due P cycles after the edge that sampled the last wake-up. The driver tags every expected output vector with the cycle it is due, and the monitor compares it in exactly that cycle at the falling clock edge. Checks just before and just after a timeout pin the window to a single cycle.

// File: rtl/canx_pkg.sv
package canx_pkg;

  typedef enum logic [2:0] {
    XS_OFFLINE  = 3'd0,
    XS_ONLINE   = 3'd1,
    XS_SELSLEEP = 3'd2,
    XS_ACTIVE   = 3'd3,
    XS_FAULT    = 3'd4
  } xcvr_state_e;

  typedef enum logic [1:0] {
    SC_STANDBY = 2'b00,
    SC_NORMAL  = 2'b01,
    SC_FLASH   = 2'b10,
    SC_SLEEP   = 2'b11
  } sysc_mode_e;

  typedef struct packed {
    logic tx_en;
    logic rx_en;
    logic term_strong;
    logic sup_en;
  } drive_t;

endpackage

// File: rtl/canx_mode_bit.sv
module canx_mode_bit
  import canx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       can_mode_i,
  input  logic [1:0] sysc_mode_i,
  input  logic       txc_i,
  output logic       cm_o,
  output logic       txc_fall_o
);

  logic req_q;
  logic cm_q, cm_n;
  logic txc_q;
  logic allowed;

  assign allowed = (sysc_mode_i == SC_NORMAL) || (sysc_mode_i == SC_FLASH);

  // set only on a request edge; held while the request stays high
  always_comb begin
    cm_n = allowed & can_mode_i & (cm_q | ~req_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      cm_q  <= 1'b0;
      txc_q <= 1'b0;
    end else begin
      req_q <= can_mode_i;
      cm_q  <= cm_n;
      txc_q <= txc_i;
    end
  end

  assign cm_o       = cm_q;
  assign txc_fall_o = txc_q & ~txc_i;

endmodule

// File: rtl/canx_offline_timer.sv
module canx_offline_timer #(
  parameter int unsigned SHORT_CYC = 20,
  parameter int unsigned LONG_CYC  = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic wake_i,
  input  logic sel_long_i,
  input  logic offline_next_i,
  output logic expire_o
);

  localparam int unsigned CNT_W = $clog2(LONG_CYC + 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_CYC - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             force_q, force_n;
  logic [CNT_W-1:0] last_sel;

  assign last_sel = (force_q | sel_long_i) ? LONG_LAST : SHORT_LAST;

  always_comb begin
    force_n = force_q;
    if (offline_next_i)
      force_n = 1'b1;
    else if (run_i && wake_i)
      force_n = 1'b0;
  end

  always_comb begin
    cnt_n = cnt_q;
    if (!run_i || wake_i)
      cnt_n = '0;
    else if (cnt_q != LONG_LAST)
      cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      force_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_n;
      force_q <= force_n;
    end
  end

  assign expire_o = run_i & ~wake_i & (cnt_q == last_sel);

endmodule

// File: rtl/canx_mode_fsm.sv
module canx_mode_fsm
  import canx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cm_i,
  input  logic        pnc_i,
  input  logic        wake_i,
  input  logic        sup_fail_i,
  input  logic        txc_fall_i,
  input  logic        expire_i,
  input  logic        irq_en_i,
  output xcvr_state_e state_o,
  output xcvr_state_e state_n_o,
  output logic        irq_o,
  output logic        wake_ff_o
);

  xcvr_state_e state_q, state_n;
  logic        irq_q, irq_n;
  logic        wake_ff_q, wake_ff_n;

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      XS_OFFLINE: begin
        if (cm_i)                 state_n = XS_ACTIVE;
        else if (wake_i && !pnc_i) state_n = XS_ONLINE;
      end
      XS_ONLINE: begin
        if (cm_i)          state_n = XS_ACTIVE;
        else if (pnc_i)    state_n = XS_SELSLEEP;
        else if (expire_i) state_n = XS_OFFLINE;
      end
      XS_SELSLEEP: begin
        if (cm_i)          state_n = XS_ACTIVE;
        else if (!pnc_i)   state_n = XS_ONLINE;
        else if (expire_i) state_n = XS_OFFLINE;
      end
      XS_ACTIVE: begin
        if (sup_fail_i)    state_n = XS_FAULT;
        else if (!cm_i)    state_n = pnc_i ? XS_SELSLEEP : XS_ONLINE;
      end
      XS_FAULT: begin
        if (!cm_i)           state_n = XS_OFFLINE;
        else if (txc_fall_i) state_n = XS_ACTIVE;
      end
      default: state_n = XS_OFFLINE;
    endcase
  end

  always_comb begin
    irq_n     = (state_q == XS_ACTIVE) & sup_fail_i & irq_en_i;
    wake_ff_n = (state_n == XS_ONLINE) & (wake_ff_q | wake_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= XS_OFFLINE;
      irq_q     <= 1'b0;
      wake_ff_q <= 1'b0;
    end else begin
      state_q   <= state_n;
      irq_q     <= irq_n;
      wake_ff_q <= wake_ff_n;
    end
  end

  assign state_o   = state_q;
  assign state_n_o = state_n;
  assign irq_o     = irq_q;
  assign wake_ff_o = wake_ff_q;

endmodule

// File: rtl/can_xcvr_mode_ctrl.sv
module can_xcvr_mode_ctrl
  import canx_pkg::*;
#(
  parameter int unsigned SHORT_CYC = 20,
  parameter int unsigned LONG_CYC  = 50,
  parameter int unsigned RST_SYNC  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       can_mode_i,
  input  logic       tx_off_i,
  input  logic       txc_i,
  input  logic       pnc_i,
  input  logic       otsel_i,
  input  logic [1:0] sysc_mode_i,
  input  logic       irq_en_i,
  input  logic       sup_fail_i,
  input  logic       wake_i,
  output logic       tx_en_o,
  output logic       rx_en_o,
  output logic       term_strong_o,
  output logic       sup_en_o,
  output logic       rxd_low_o,
  output logic       fail_o,
  output logic       irq_o,
  output logic       can_mode_o
);

  // reset: asserted asynchronously, released after RST_SYNC edges
  logic [RST_SYNC-1:0] rst_pipe_q;
  logic                rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_SYNC-2:0], 1'b1};
  end
  assign rst_s_n = rst_pipe_q[RST_SYNC-1];

  logic        cm;
  logic        txc_fall;
  logic        expire;
  logic        run;
  logic        wake_ff;
  xcvr_state_e state_q, state_n;
  drive_t      drv;

  canx_mode_bit u_mode_bit (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .can_mode_i  (can_mode_i),
    .sysc_mode_i (sysc_mode_i),
    .txc_i       (txc_i),
    .cm_o        (cm),
    .txc_fall_o  (txc_fall)
  );

  assign run = (state_q == XS_ONLINE) || (state_q == XS_SELSLEEP);

  canx_offline_timer #(
    .SHORT_CYC (SHORT_CYC),
    .LONG_CYC  (LONG_CYC)
  ) u_timer (
    .clk            (clk),
    .rst_n          (rst_s_n),
    .run_i          (run),
    .wake_i         (wake_i),
    .sel_long_i     (otsel_i),
    .offline_next_i (state_n == XS_OFFLINE),
    .expire_o       (expire)
  );

  canx_mode_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .cm_i       (cm),
    .pnc_i      (pnc_i),
    .wake_i     (wake_i),
    .sup_fail_i (sup_fail_i),
    .txc_fall_i (txc_fall),
    .expire_i   (expire),
    .irq_en_i   (irq_en_i),
    .state_o    (state_q),
    .state_n_o  (state_n),
    .irq_o      (irq_o),
    .wake_ff_o  (wake_ff)
  );

  always_comb begin
    drv = '0;
    unique case (state_q)
      XS_ONLINE, XS_SELSLEEP: begin
        drv.rx_en       = 1'b1;
        drv.term_strong = 1'b1;
        drv.sup_en      = 1'b1;
      end
      XS_ACTIVE: begin
        drv.tx_en       = cm & ~tx_off_i;
        drv.rx_en       = 1'b1;
        drv.term_strong = 1'b1;
        drv.sup_en      = 1'b1;
      end
      default: drv = '0;
    endcase
  end

  assign tx_en_o       = drv.tx_en;
  assign rx_en_o       = drv.rx_en;
  assign term_strong_o = drv.term_strong;
  assign sup_en_o      = drv.sup_en;
  assign rxd_low_o     = wake_ff;
  assign fail_o        = (state_q == XS_FAULT);
  assign can_mode_o    = cm;

endmodule

// File: rtl/can_xcvr_mode_ctrl_chk.sv
module can_xcvr_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_off_i,
  input logic [1:0] sysc_mode_i,
  input logic       tx_en_o,
  input logic       rx_en_o,
  input logic       term_strong_o,
  input logic       sup_en_o,
  input logic       rxd_low_o,
  input logic       fail_o,
  input logic       irq_o,
  input logic       can_mode_o
);

  // R1: outside Normal/Flash the mode bit is clear on the next edge
  a_r1_mode_autoclear: assert property (@(posedge clk) disable iff (!rst_n)
    (sysc_mode_i == 2'b00 || sysc_mode_i == 2'b11) |=> !can_mode_o);

  // R2: transmitter turns on only after the mode bit was set
  a_r2_tx_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en_o) |-> $past(can_mode_o));

  // R3: listen-only keeps the transmitter off
  a_r3_listen_only: assert property (@(posedge clk) disable iff (!rst_n)
    tx_off_i |-> !tx_en_o);

  // R4: fault entry switches every enable off
  a_r4_fault_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_o) |-> (!sup_en_o && !rx_en_o && !term_strong_o && !tx_en_o));

  // R4: an interrupt only accompanies a fault and lasts one cycle
  a_r4_irq_with_fail: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (fail_o && $rose(fail_o)));

  // R8: RXD override only while receiving without transmitting
  a_r8_rxd_online: assert property (@(posedge clk) disable iff (!rst_n)
    rxd_low_o |-> (rx_en_o && !tx_en_o && sup_en_o));

endmodule

bind can_xcvr_mode_ctrl can_xcvr_mode_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .tx_off_i      (tx_off_i),
  .sysc_mode_i   (sysc_mode_i),
  .tx_en_o       (tx_en_o),
  .rx_en_o       (rx_en_o),
  .term_strong_o (term_strong_o),
  .sup_en_o      (sup_en_o),
  .rxd_low_o     (rxd_low_o),
  .fail_o        (fail_o),
  .irq_o         (irq_o),
  .can_mode_o    (can_mode_o)
);

// File: tb/can_xcvr_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module can_xcvr_mode_ctrl_tb_top;

  localparam int SHORT_CYC = 20;
  localparam int LONG_CYC  = 50;
  localparam int WATCHDOG  = 20000;

  // output vector: [7]cm [6]irq [5]fail [4]rxd [3]sup [2]term [1]rx [0]tx
  localparam logic [7:0] V_OFF = 8'h00;
  localparam logic [7:0] V_AUT = 8'h0E;
  localparam logic [7:0] V_RXD = 8'h10;
  localparam logic [7:0] V_CM  = 8'h80;
  localparam logic [7:0] V_ACT = 8'h8F;
  localparam logic [7:0] V_FLT = 8'hA0;
  localparam logic [7:0] V_IRQ = 8'hE0;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       can_mode_i, tx_off_i, txc_i, pnc_i, otsel_i, irq_en_i;
  logic       sup_fail_i, wake_i;
  logic [1:0] sysc_mode_i;
  logic       tx_en_o, rx_en_o, term_strong_o, sup_en_o;
  logic       rxd_low_o, fail_o, irq_o, can_mode_o;

  always #2 clk = ~clk;

  can_xcvr_mode_ctrl #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .can_mode_i(can_mode_i), .tx_off_i(tx_off_i),
    .txc_i(txc_i), .pnc_i(pnc_i), .otsel_i(otsel_i), .sysc_mode_i(sysc_mode_i),
    .irq_en_i(irq_en_i), .sup_fail_i(sup_fail_i), .wake_i(wake_i),
    .tx_en_o(tx_en_o), .rx_en_o(rx_en_o), .term_strong_o(term_strong_o),
    .sup_en_o(sup_en_o), .rxd_low_o(rxd_low_o), .fail_o(fail_o),
    .irq_o(irq_o), .can_mode_o(can_mode_o)
  );

  typedef struct {
    int         due;
    string      req;
    logic [7:0] exp;
  } item_t;

  item_t q[$];
  int    cyc = 0;
  int    total = 0;
  int    bad = 0;
  bit    done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(input int due, input string req, input logic [7:0] exp);
    item_t it;
    it.due = due;
    it.req = req;
    it.exp = exp;
    q.push_back(it);
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  // monitor: compare every item due in this cycle
  always @(negedge clk) begin
    logic [7:0] act;
    act = {can_mode_o, irq_o, fail_o, rxd_low_o, sup_en_o, term_strong_o, rx_en_o, tx_en_o};
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due <= cyc) begin
        total++;
        if (q[i].due < cyc || act !== q[i].exp) begin
          bad++;
          $display("FAIL %s cycle %0d: actual=%h expected=%h", q[i].req, cyc, act, q[i].exp);
        end
        q.delete(i);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > WATCHDOG && !done) begin
      done = 1'b1;
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; can_mode_i = 0; tx_off_i = 0; txc_i = 0; pnc_i = 0;
    otsel_i = 0; irq_en_i = 1; sup_fail_i = 0; wake_i = 0;
    sysc_mode_i = 2'b01;
    step(3);
    push(cyc, "R10", V_OFF);                  // reset state
    step(1);
    rst_n = 1'b1;
    step(5);
    push(cyc, "R10", V_OFF);

    // R7: wake-up ignored in Off-line while partial networking is on
    pnc_i = 1; wake_i = 1;
    push(cyc + 1, "R7", V_OFF);
    step(1); wake_i = 0; pnc_i = 0;
    push(cyc + 1, "R7", V_OFF);
    step(2);

    // R1: request edge in Standby is ignored, no later set without an edge
    sysc_mode_i = 2'b00; can_mode_i = 1;
    push(cyc + 1, "R1", V_OFF);
    step(1); sysc_mode_i = 2'b01;
    push(cyc + 1, "R1", V_OFF);
    push(cyc + 2, "R1", V_OFF);
    step(3); can_mode_i = 0;
    step(2);

    // R7: wake-up moves Off-line to On-line with RXD held low
    wake_i = 1;
    push(cyc + 1, "R7", V_AUT | V_RXD);
    step(1); wake_i = 0;
    push(cyc + 1, "R8", V_AUT | V_RXD);
    step(2);

    // R1/R2/R8: mode bit after one cycle, Active after two, RXD released
    can_mode_i = 1;
    push(cyc + 1, "R1", V_AUT | V_RXD | V_CM);
    push(cyc + 2, "R2", V_ACT);
    step(3);

    // R3: listen-only, same cycle
    tx_off_i = 1;
    push(cyc, "R3", V_ACT & 8'hFE);
    step(1); tx_off_i = 0;
    push(cyc, "R3", V_ACT);
    step(1);

    // R4: supply fault
    sup_fail_i = 1;
    push(cyc + 1, "R4", V_IRQ);
    step(1); sup_fail_i = 0;
    push(cyc + 1, "R4", V_FLT);
    step(2);

    // R5: rising txc does nothing, falling txc retries
    txc_i = 1;
    push(cyc, "R5", V_FLT);
    step(1);
    push(cyc, "R5", V_FLT);
    txc_i = 0;
    push(cyc + 1, "R5", V_ACT);
    step(2);

    // R5: second fault raises a new interrupt, then retry again
    sup_fail_i = 1;
    push(cyc + 1, "R5", V_IRQ);
    step(1); sup_fail_i = 0;
    push(cyc + 1, "R5", V_FLT);
    step(1); txc_i = 1;
    step(1); txc_i = 0;
    push(cyc + 1, "R5", V_ACT);
    step(2);

    // R6: mode clear with partial networking -> Selective Sleep
    can_mode_i = 0; pnc_i = 1;
    push(cyc + 1, "R6", V_AUT);
    push(cyc + 2, "R6", V_AUT);
    step(3);
    // R8: wake-up in Selective Sleep keeps RXD high
    wake_i = 1;
    push(cyc + 1, "R8", V_AUT);
    step(1); wake_i = 0;
    push(cyc + 1, "R8", V_AUT);
    step(1);

    // R6: back to On-line, no pending wake-up
    pnc_i = 0;
    push(cyc + 1, "R6", V_AUT);
    step(2);

    // R9: short period after a wake-up inside an Auto state
    wake_i = 1;
    push(cyc + 1, "R8", V_AUT | V_RXD);
    step(1); wake_i = 0;
    push(cyc + SHORT_CYC - 1, "R9", V_AUT | V_RXD);
    push(cyc + SHORT_CYC, "R9", V_OFF);
    step(SHORT_CYC + 2);

    // R9: first timeout after Off-line uses the long period
    wake_i = 1;
    push(cyc + 1, "R7", V_AUT | V_RXD);
    step(1); wake_i = 0;
    push(cyc + LONG_CYC - 1, "R9", V_AUT | V_RXD);
    push(cyc + LONG_CYC, "R9", V_OFF);
    step(LONG_CYC + 2);

    // R9: timer select long after a clearing wake-up
    otsel_i = 1; wake_i = 1;
    step(1);
    step(1); wake_i = 0;
    push(cyc + LONG_CYC - 1, "R9", V_AUT | V_RXD);
    push(cyc + LONG_CYC, "R9", V_OFF);
    step(LONG_CYC + 2);
    otsel_i = 0;

    // R2: Active straight from Off-line
    can_mode_i = 1;
    push(cyc + 1, "R1", V_CM);
    push(cyc + 2, "R2", V_ACT);
    step(3);
    sup_fail_i = 1;
    push(cyc + 1, "R4", V_IRQ);
    step(1); sup_fail_i = 0;
    // R1: leaving Normal clears the mode bit; R5: fault without mode -> Off-line
    sysc_mode_i = 2'b11;
    push(cyc + 1, "R1", V_FLT & 8'h7F);
    push(cyc + 2, "R5", V_OFF);
    step(3);
    sysc_mode_i = 2'b01;
    push(cyc + 1, "R1", V_OFF);
    push(cyc + 3, "R1", V_OFF);
    step(5);

    if (q.size() != 0) begin
      bad++;
      total++;
      $display("FAIL pending: actual=%0d expected=0", q.size());
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule